// File: doc/BRIEF.md
# Serial Frame Check-Byte Guard

This block sits beside a serial register slave and adds CRC-8 protection to its command frames. With protection off, a frame is a 16-bit command: one direction bit (0 = write, 1 = read), a 7-bit address and an 8-bit data byte. With protection on, the frame is 24 clocks long, and the last eight clocks carry a check byte. The guard runs a serial CRC over the 16 payload bits as they arrive. The generator is x^8+x^2+x+1 (0x07), the seed is zero, and bits are taken most significant first. On a write, the guard compares the CRC with the check byte from the host. The register commit is permitted only if the two agree. On a read, the guard sends the CRC of the returned command out to the host.

The guard does not see the serial clock itself. The slave gives it single-cycle strobes in the system clock domain: the chip-select fall (frame start), the chip-select rise (frame end), the serial clock rising edge (the serial input is valid on this one) and the serial clock falling edge. A sequencer tracks where the frame is. Its states are FR_IDLE, FR_HEAD (edges 1 to 8), FR_BODY (edges 9 to 16), FR_CHECK (edges 17 to 24) and FR_TAIL (past the expected length). The transitions are:
- frame start: any state to FR_HEAD
- frame end: any state to FR_IDLE
- 8th rising edge: FR_HEAD to FR_BODY
- 16th rising edge: FR_BODY to FR_CHECK when protection is on, or FR_BODY to FR_TAIL when it is off
- 24th rising edge: FR_CHECK to FR_TAIL

Register storage belongs to the slave.

Top module: `spi_crc8_guard`

## Requirements
- R1: After reset, wr_permit, crc_err, sclk_err and chk_sdo_oe are 0, and protection counts as off until crc_en is sampled high at a frame start.
- R2: The check value is a CRC with generator 0x07 and seed 0. It is computed MSB first over 16 bits: the direction bit, address bits 6..0, then data bits 7..0. Frame start clears the CRC register.
- R3: With protection on, a write frame (direction bit 0) whose eight bits after the 16th rising edge equal the CRC (MSB first) raises wr_permit for exactly one cycle. That cycle is the one after the strobe of the 24th rising edge.
- R4: With protection on, a write frame whose check byte differs from the CRC gives no wr_permit. It sets crc_err in the cycle after the 24th rising edge strobe.
- R5: crc_err and sclk_err stay high until err_clr is sampled high. If a set and err_clr fall in the same cycle, the set wins.
- R6: With protection off, a write frame raises wr_permit for one cycle after the 16th rising edge strobe. No check byte is expected.
- R7: A read frame (direction bit 1) never raises wr_permit.
- R8: With protection on, in a read frame the CRC covers the direction bit, the address and rd_byte as sent (bit 7 first), and sdi is ignored on edges 9 to 16. After each falling-edge strobe that follows rising edges 16 to 23, chk_sdo_oe is 1 and chk_sdo carries the CRC bits, MSB first. After any other falling-edge strobe, chk_sdo_oe is 0.
- R9: A frame that ends with a rising-edge count other than its expected length (24 when protected, 16 otherwise) sets sclk_err. A protected write that ends after 16 edges gives no wr_permit, and edges past the expected length give no further permit.
- R10: A frame start restarts counting from any state. A frame end returns to idle, drops chk_sdo_oe, and makes later edges have no effect until the next frame start.
- R11: crc_en is sampled only at frame start. A change during a frame does not alter that frame's length or checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_en | input | 1 | Protection enable, sampled at frame start |
| frame_start | input | 1 | Strobe: chip select fell |
| frame_end | input | 1 | Strobe: chip select rose |
| sclk_rise | input | 1 | Strobe: serial clock rising edge, sdi valid |
| sclk_fall | input | 1 | Strobe: serial clock falling edge |
| sdi | input | 1 | Serial data from host |
| rd_byte | input | 8 | Byte the slave returns for the addressed register |
| err_clr | input | 1 | Clears both sticky error flags |
| wr_permit | output | 1 | One-cycle pulse allowing the register commit |
| crc_err | output | 1 | Sticky check-byte mismatch flag |
| sclk_err | output | 1 | Sticky wrong-edge-count flag |
| chk_sdo | output | 1 | Check-byte bit toward host |
| chk_sdo_oe | output | 1 | Drive enable for chk_sdo |

## Verification
The embedded assertions check every cycle that a permit is a lone pulse, never appears in a read frame, and never coincides with a new mismatch. They also check that the error flags stay set without a clear, that the output is driven only in protected reads, that a frame start restarts the sequencer and that a frame end idles it. Whether the CRC value is right, whether the right edge commits, and whether short or long frames set the clock-count flag can only be shown by the bench scenarios. The bench covers those against its own model, through the permit pulses and the captured check byte.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_HEAD,
        FR_BODY,
        FR_CHECK,
        FR_TAIL
    } fr_state_t;

endpackage

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
    import spi_crc_pkg::*;
#(
    parameter int HDR_BITS  = 8,
    parameter int DATA_BITS = 8,
    parameter int CHK_BITS  = 8,
    parameter int CNT_W     = 6,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             sclk_rise,
    input  logic             sdi,
    input  logic             chk_en_in,
    output logic             is_rd,
    output logic             chk_on,
    output logic             pay_take,
    output logic             chk_take,
    output logic             commit_edge,
    output logic             end_bad,
    output logic             tx_win,
    output logic [IDX_W-1:0] chk_pos,
    output logic [CNT_W-1:0] edge_n
);

    localparam int PAY_BITS  = HDR_BITS + DATA_BITS;
    localparam int FULL_BITS = PAY_BITS + CHK_BITS;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] PAY_END  = CNT_W'(PAY_BITS);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(FULL_BITS);

    fr_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             is_rd_q;
    logic             chk_on_q;
    logic [CNT_W-1:0] frame_len;
    logic             rise_only;

    assign edge_n    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign frame_len = chk_on_q ? FULL_END : PAY_END;
    assign rise_only = sclk_rise && !frame_start && !frame_end;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = FR_HEAD;
        end else if (frame_end) begin
            state_d = FR_IDLE;
        end else if (sclk_rise) begin
            unique case (state_q)
                FR_IDLE:  state_d = FR_IDLE;
                FR_HEAD:  if (edge_n == HDR_END) state_d = FR_BODY;
                FR_BODY:  if (edge_n == PAY_END) state_d = chk_on_q ? FR_CHECK : FR_TAIL;
                FR_CHECK: if (edge_n == FULL_END) state_d = FR_TAIL;
                FR_TAIL:  state_d = FR_TAIL;
                default:  state_d = FR_IDLE;
            endcase
        end
    end

    // state register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FR_IDLE;
            cnt_q    <= '0;
            is_rd_q  <= 1'b0;
            chk_on_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                cnt_q    <= '0;
                is_rd_q  <= 1'b0;
                chk_on_q <= chk_en_in;
            end else if (rise_only && state_q != FR_IDLE) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (state_q == FR_HEAD && cnt_q == '0) is_rd_q <= sdi;
            end
        end
    end

    // strobe decode toward the datapath
    always_comb begin
        pay_take    = rise_only && (state_q == FR_HEAD || state_q == FR_BODY);
        chk_take    = rise_only && (state_q == FR_CHECK);
        commit_edge = rise_only && (state_q == FR_BODY || state_q == FR_CHECK)
                      && (edge_n == frame_len);
        end_bad     = frame_end && !frame_start && (state_q != FR_IDLE)
                      && (cnt_q != frame_len);
        tx_win      = (state_q == FR_CHECK) && is_rd_q;
        chk_pos     = IDX_W'(cnt_q - PAY_END);
        is_rd       = is_rd_q;
        chk_on      = chk_on_q;
    end

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == FR_HEAD && cnt_q == '0));

    assert_idle_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_start) |=> (state_q == FR_IDLE));

    assert_check_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_CHECK) |-> chk_on_q);

endmodule

// File: rtl/sc_crc_lfsr.sv
module sc_crc_lfsr #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  POLY = 'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic         fb;

    assign fb  = crc_q[W-1] ^ din;
    assign crc = crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
        end
    end

    assert_zero_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(crc_q));

endmodule

// File: rtl/sc_chk_port.sv
module sc_chk_port #(
    parameter int CHK_BITS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_end,
    input  logic                sclk_fall,
    input  logic                chk_take,
    input  logic                sdi,
    input  logic                tx_win,
    input  logic [IDX_W-1:0]    chk_pos,
    input  logic [CHK_BITS-1:0] crc_val,
    output logic [CHK_BITS-1:0] rx_next,
    output logic                sdo_bit,
    output logic                sdo_oe
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CHK_BITS - 1);

    logic [CHK_BITS-1:0] rx_q;
    logic [IDX_W-1:0]    tx_idx;

    assign rx_next = {rx_q[CHK_BITS-2:0], sdi};
    assign tx_idx  = TOP_IDX - chk_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (frame_start) begin
            rx_q <= '0;
        end else if (chk_take) begin
            rx_q <= rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_oe  <= 1'b0;
            sdo_bit <= 1'b0;
        end else if (frame_start || frame_end) begin
            sdo_oe  <= 1'b0;
            sdo_bit <= 1'b0;
        end else if (sclk_fall) begin
            sdo_oe  <= tx_win;
            sdo_bit <= tx_win ? crc_val[tx_idx] : 1'b0;
        end
    end

    assert_quiet_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end || frame_start) |=> !sdo_oe);

endmodule

// File: rtl/spi_crc8_guard.sv
module spi_crc8_guard #(
    parameter int HDR_BITS  = 8,
    parameter int DATA_BITS = 8,
    parameter int CHK_BITS  = 8,
    parameter logic [CHK_BITS-1:0] CHK_POLY = 'h07
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 crc_en,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 sdi,
    input  logic [DATA_BITS-1:0] rd_byte,
    input  logic                 err_clr,
    output logic                 wr_permit,
    output logic                 crc_err,
    output logic                 sclk_err,
    output logic                 chk_sdo,
    output logic                 chk_sdo_oe
);

    localparam int PAY_BITS  = HDR_BITS + DATA_BITS;
    localparam int FULL_BITS = PAY_BITS + CHK_BITS;
    localparam int CNT_W     = $clog2(FULL_BITS + 1) + 1;
    localparam int IDX_W     = (CHK_BITS > 1) ? $clog2(CHK_BITS) : 1;

    logic                is_rd, chk_on;
    logic                pay_take, chk_take, commit_edge, end_bad, tx_win;
    logic [IDX_W-1:0]    chk_pos;
    logic [CNT_W-1:0]    edge_n;
    logic [CHK_BITS-1:0] crc_val, rx_next;
    logic                pay_bit, match;

    sc_frame_seq #(
        .HDR_BITS (HDR_BITS),
        .DATA_BITS(DATA_BITS),
        .CHK_BITS (CHK_BITS),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .sclk_rise  (sclk_rise),
        .sdi        (sdi),
        .chk_en_in  (crc_en),
        .is_rd      (is_rd),
        .chk_on     (chk_on),
        .pay_take   (pay_take),
        .chk_take   (chk_take),
        .commit_edge(commit_edge),
        .end_bad    (end_bad),
        .tx_win     (tx_win),
        .chk_pos    (chk_pos),
        .edge_n     (edge_n)
    );

    // payload bit: on reads the data half comes from the returned byte
    always_comb begin
        pay_bit = sdi;
        if (is_rd) begin
            for (int i = 0; i < DATA_BITS; i++) begin
                if (edge_n == CNT_W'(PAY_BITS - i)) pay_bit = rd_byte[i];
            end
        end
    end

    sc_crc_lfsr #(
        .W   (CHK_BITS),
        .POLY(CHK_POLY)
    ) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (frame_start),
        .step (pay_take),
        .din  (pay_bit),
        .crc  (crc_val)
    );

    sc_chk_port #(
        .CHK_BITS(CHK_BITS),
        .IDX_W   (IDX_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .sclk_fall  (sclk_fall),
        .chk_take   (chk_take),
        .sdi        (sdi),
        .tx_win     (tx_win),
        .chk_pos    (chk_pos),
        .crc_val    (crc_val),
        .rx_next    (rx_next),
        .sdo_bit    (chk_sdo),
        .sdo_oe     (chk_sdo_oe)
    );

    assign match = (rx_next == crc_val);

    // commit permit and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_permit <= 1'b0;
            crc_err   <= 1'b0;
            sclk_err  <= 1'b0;
        end else begin
            wr_permit <= commit_edge && !is_rd && (!chk_on || match);
            if (commit_edge && chk_on && !is_rd && !match) crc_err <= 1'b1;
            else if (err_clr)                                crc_err <= 1'b0;
            if (end_bad)      sclk_err <= 1'b1;
            else if (err_clr) sclk_err <= 1'b0;
        end
    end

    assert_permit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |=> !wr_permit);

    assert_no_permit_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> !is_rd);

    assert_permit_excl_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> !$rose(crc_err));

    assert_crc_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);

    assert_sclk_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_err && !err_clr) |=> sclk_err);

    assert_drive_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_sdo_oe |-> (is_rd && chk_on));

endmodule

// File: tb/sim_spi_crc8_guard.sv
module sim_spi_crc8_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_en = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
    logic       sclk_rise = 1'b0, sclk_fall = 1'b0, sdi = 1'b0, err_clr = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       wr_permit, crc_err, sclk_err, chk_sdo, chk_sdo_oe;

    int checks = 0, errors = 0, perm_seen = 0, cyc = 0;

    always #5 clk = ~clk;

    spi_crc8_guard u0 (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frame_start(frame_start),
        .frame_end(frame_end), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi(sdi), .rd_byte(rd_byte), .err_clr(err_clr), .wr_permit(wr_permit),
        .crc_err(crc_err), .sclk_err(sclk_err), .chk_sdo(chk_sdo), .chk_sdo_oe(chk_sdo_oe)
    );

    function automatic logic [7:0] ref_crc(input logic [15:0] p);
        logic [7:0] c = 8'h00;
        for (int k = 15; k >= 0; k--) begin
            logic f = c[7] ^ p[k];
            c = {c[6:0], 1'b0};
            if (f) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic       m_permit, m_cerr, m_serr, m_oe, m_sdo, m_active, m_rd;
    int         m_cnt, m_len;
    logic [7:0] m_crc, m_rx;
    logic [15:0] m_pay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_permit <= 0; m_cerr <= 0; m_serr <= 0; m_oe <= 0; m_sdo <= 0;
            m_active <= 0; m_rd <= 0; m_cnt <= 0; m_len <= 16;
            m_crc <= 0; m_rx <= 0; m_pay <= 0;
        end else begin
            logic set_c, set_s;
            set_c = 0; set_s = 0;
            m_permit <= 0;
            if (frame_start) begin
                m_active <= 1; m_cnt <= 0; m_len <= crc_en ? 24 : 16;
                m_rd <= 0; m_pay <= 0; m_rx <= 0; m_oe <= 0; m_sdo <= 0; m_crc <= 0;
            end else if (frame_end) begin
                if (m_active && m_cnt != m_len) set_s = 1;
                m_active <= 0; m_oe <= 0; m_sdo <= 0;
            end else if (sclk_rise) begin
                if (m_active) begin
                    int n;
                    n = m_cnt + 1;
                    m_cnt <= n;
                    if (n == 1) m_rd <= sdi;
                    if (n <= 16) begin
                        logic b;
                        logic [15:0] pn;
                        b = (m_rd && n > 8) ? rd_byte[16-n] : sdi;
                        pn = {m_pay[14:0], b};
                        m_pay <= pn;
                        if (n == 16) begin
                            m_crc <= ref_crc(pn);
                            if (m_len == 16 && !m_rd) m_permit <= 1;
                        end
                    end else if (n <= 24 && m_len == 24) begin
                        logic [7:0] rn;
                        rn = {m_rx[6:0], sdi};
                        m_rx <= rn;
                        if (n == 24 && !m_rd) begin
                            if (rn == m_crc) m_permit <= 1;
                            else set_c = 1;
                        end
                    end
                end
            end else if (sclk_fall) begin
                if (m_active && m_len == 24 && m_rd && m_cnt >= 16 && m_cnt <= 23) begin
                    m_oe <= 1; m_sdo <= m_crc[23-m_cnt];
                end else begin
                    m_oe <= 0; m_sdo <= 0;
                end
            end
            m_cerr <= set_c ? 1'b1 : (err_clr ? 1'b0 : m_cerr);
            m_serr <= set_s ? 1'b1 : (err_clr ? 1'b0 : m_serr);
        end
    end

    // every-clock comparison
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R3 wr_permit", wr_permit, m_permit);
            check("R4 crc_err", crc_err, m_cerr);
            check("R9 sclk_err", sclk_err, m_serr);
            check("R10 chk_sdo_oe", chk_sdo_oe, m_oe);
            check("R8 chk_sdo", chk_sdo, m_sdo);
            if (wr_permit) perm_seen++;
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic run_frame(input bit en, input bit rd, input logic [6:0] addr,
                             input logic [7:0] dat, input logic [7:0] rdb, input bit bad,
                             input int nrise, input bit en_after, input bit do_end,
                             output logic [7:0] cap, output int ncap);
        logic [15:0] pay;
        logic [7:0]  chk;
        cap = 0; ncap = 0;
        pay = {rd, addr, rd ? rdb : dat};
        chk = ref_crc(pay) ^ (bad ? 8'h01 : 8'h00);
        @(negedge clk) crc_en = en; rd_byte = rdb; frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0; crc_en = en_after;
        for (int i = 1; i <= nrise; i++) begin
            if (i <= 16) sdi = (rd && i > 8) ? 1'b1 : pay[16-i];
            else if (i <= 24) sdi = chk[24-i];
            else sdi = 1'b0;
            pulse(sclk_rise);
            pulse(sclk_fall);
            #1;
            if (chk_sdo_oe) begin cap = {cap[6:0], chk_sdo}; ncap++; end
        end
        if (do_end) pulse(frame_end);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        int ncap, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wr_permit", wr_permit, 0);
        check("R1 crc_err", crc_err, 0);
        check("R1 sclk_err", sclk_err, 0);
        check("R1 chk_sdo_oe", chk_sdo_oe, 0);

        // R6 unprotected write
        p0 = perm_seen;
        run_frame(0, 0, 7'h12, 8'hA5, 8'h00, 0, 16, 0, 1, cap, ncap);
        check("R6 permit count", perm_seen - p0, 1);

        // R3 protected write, good check byte
        p0 = perm_seen;
        run_frame(1, 0, 7'h2C, 8'h3C, 8'h00, 0, 24, 1, 1, cap, ncap);
        check("R3 permit count", perm_seen - p0, 1);
        check("R3 no crc_err", crc_err, 0);

        // R4 bad check byte
        p0 = perm_seen;
        run_frame(1, 0, 7'h2C, 8'h3C, 8'h00, 1, 24, 1, 1, cap, ncap);
        check("R4 permit count", perm_seen - p0, 0);
        check("R4 crc_err set", crc_err, 1);

        // R5 sticky until clear
        run_frame(1, 0, 7'h01, 8'h02, 8'h00, 0, 24, 1, 1, cap, ncap);
        check("R5 crc_err held", crc_err, 1);
        pulse(err_clr);
        @(negedge clk);
        check("R5 crc_err cleared", crc_err, 0);

        // R8 and R2 protected read, check byte out
        p0 = perm_seen;
        run_frame(1, 1, 7'h55, 8'h00, 8'hC3, 0, 24, 1, 1, cap, ncap);
        check("R8 bits captured", ncap, 8);
        check("R2 read check byte", cap, ref_crc({1'b1, 7'h55, 8'hC3}));
        check("R7 read permit count", perm_seen - p0, 0);

        // R7 unprotected read
        p0 = perm_seen;
        run_frame(0, 1, 7'h07, 8'h00, 8'h99, 0, 16, 0, 1, cap, ncap);
        check("R7 unprotected read permits", perm_seen - p0, 0);
        check("R8 no drive unprotected", ncap, 0);

        // R9 protected write cut short
        p0 = perm_seen;
        run_frame(1, 0, 7'h11, 8'h22, 8'h00, 0, 16, 1, 1, cap, ncap);
        check("R9 short frame permits", perm_seen - p0, 0);
        check("R9 sclk_err set", sclk_err, 1);
        pulse(err_clr);
        @(negedge clk);
        check("R5 sclk_err cleared", sclk_err, 0);

        // R9 unprotected write too long
        p0 = perm_seen;
        run_frame(0, 0, 7'h33, 8'h44, 8'h00, 0, 20, 0, 1, cap, ncap);
        check("R9 long frame permits", perm_seen - p0, 1);
        check("R9 long frame sclk_err", sclk_err, 1);
        pulse(err_clr);

        // R11 enable dropped mid-frame
        p0 = perm_seen;
        run_frame(1, 0, 7'h4A, 8'hF0, 8'h00, 0, 24, 0, 1, cap, ncap);
        check("R11 frame stays protected", perm_seen - p0, 1);
        check("R11 no sclk_err", sclk_err, 0);

        // R10 restart mid-frame, then stray edges after end
        p0 = perm_seen;
        run_frame(1, 0, 7'h0F, 8'h0F, 8'h00, 0, 10, 1, 0, cap, ncap);
        run_frame(1, 0, 7'h70, 8'h81, 8'h00, 0, 24, 1, 1, cap, ncap);
        pulse(sclk_rise);
        pulse(sclk_fall);
        check("R10 restart permits", perm_seen - p0, 1);
        check("R10 no sclk_err", sclk_err, 0);

        // R2 several payloads through the write path
        p0 = perm_seen;
        for (int k = 0; k < 8; k++) begin
            run_frame(1, 0, 7'(k * 37 + 5), 8'(k * 91 + 13), 8'h00, 0, 24, 1, 1, cap, ncap);
        end
        check("R2 payload sweep permits", perm_seen - p0, 8);
        check("R2 payload sweep crc_err", crc_err, 0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule